// File: doc/BRIEF.md
# Reset-Robust Credit Link

This block is a point-to-point valid/data link with credit-based flow control. A sending endpoint and a receiving endpoint sit in separate reset domains that share a clock. The sender keeps a count of the buffer slots it may still fill. The receiver holds a bounded in-order buffer and hands back one credit for every entry its consumer removes. Either domain may go into reset and come back out at any moment, as often as it likes. The credit accounting rebuilds itself after each such event, so that no slot is lost and no slot is counted twice.

Each endpoint drives a reset-status wire to its partner and exports a two-bit state. Both ends use the same encoding: 0 means in reset, 1 means waiting for the partner, 2 means active. While a side reports reset, its partner blocks the datapath. The sender drops its credits and stops offering beats. The receiver throws away its buffered entries and any credits it still owes, then waits. Once both sides are out of reset, the receiver pays out its full capacity again, one credit per cycle. Traffic that was in the buffer at the time of a reset is discarded, not drained. Recovering lost transactions is left to the layers above.

Top module: `credit_link`

## Requirements
- R1: `src_ready` is high only while the sender state is active (2) and `snd_credits` is nonzero. A beat transfers when `src_valid` and `src_ready` are both high, and each transfer consumes one credit.
- R2: `snd_in_reset` is high during `snd_rst` and for the one cycle after it is released. `rcv_in_reset` behaves the same way with `rcv_rst`. While a side is in reset its state reads 0.
- R3: When `rcv_in_reset` is high in a cycle, `snd_credits` reads 0 in the next cycle. A sender that was active falls back to the waiting state (1).
- R4: The sender moves from waiting (1) to active (2) only after a cycle in which `rcv_in_reset` was low. While the receiver is held in reset, the sender stays in waiting with zero credits.
- R5: Once both sides are out of reset, the receiver returns its full capacity CAP (default 8) one credit per cycle. `snd_credits` never rises by more than one per cycle. With both sides released from reset together, it reaches CAP in the 12th cycle after release when CAP is 8, that is, in cycle CAP+4.
- R6: A cycle with `snd_in_reset` high makes the receiver drop every buffered entry and enter the waiting state (1). `sink_valid` stays low until new beats arrive.
- R7: Beats come out at `sink_data` in the order they were accepted, with their data intact. An entry is removed when `sink_valid` and `sink_pop` are both high, and each removal eventually returns one credit.
- R8: `snd_credits` never exceeds CAP. Once both sides have been out of reset and the link has been idle for CAP+8 cycles, `snd_credits` plus the number of entries held in the buffer equals CAP.
- R9: In any cycle where either reset-status wire is high, `src_ready` and `sink_valid` are both low. No beat crosses and no credit is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both endpoints |
| snd_rst | input | 1 | Synchronous active-high reset of the sending domain |
| rcv_rst | input | 1 | Synchronous active-high reset of the receiving domain |
| src_valid | input | 1 | Producer offers a beat |
| src_data | input | DATA_W | Data of the offered beat |
| src_ready | output | 1 | Sender can take the beat this cycle |
| sink_valid | output | 1 | Receiver buffer has an entry to hand out |
| sink_data | output | DATA_W | Oldest buffered beat |
| sink_pop | input | 1 | Consumer removes the oldest entry |
| snd_credits | output | CNT_W | Credits currently held by the sender |
| snd_state | output | 2 | Sender state: 0 reset, 1 waiting, 2 active |
| rcv_state | output | 2 | Receiver state: 0 reset, 1 waiting, 2 active |
| snd_in_reset | output | 1 | Sender reset-status wire seen by the receiver |
| rcv_in_reset | output | 1 | Receiver reset-status wire seen by the sender |

## Verification
The bench targets the moments where a reset lands next to live traffic. These include a receiver reset while the sender holds credits, a one-cycle sender reset with beats sitting in the buffer, and both sides resetting in the same cycle. A design that kept credits across a partner reset would later hold more than CAP credits and overrun the buffer. One that failed to flush would hand out stale beats. Directed cases pin down the exact cycle in which the credit count refills after release and the point at which a full buffer stops the sender. Random epochs of traffic with independent resets on each side end with an idle period, after which the bench checks that credits plus stored entries equal CAP. A design that leaks or duplicates credits drifts away from that sum within a few epochs.

// File: rtl/credit_link_pkg.sv
package credit_link_pkg;

    typedef enum logic [1:0] {
        TX_RESET  = 2'd0,
        TX_WAIT   = 2'd1,
        TX_ACTIVE = 2'd2
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_RESET  = 2'd0,
        RX_WAIT   = 2'd1,
        RX_ACTIVE = 2'd2
    } rx_state_e;

endpackage

// File: rtl/credit_link_tx.sv
// Sending endpoint: credit counter and handshake state.
module credit_link_tx
    import credit_link_pkg::*;
#(
    parameter int CAP   = 8,
    parameter int CNT_W = $clog2(CAP + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up_valid,
    output logic             up_ready,
    output logic             link_valid,
    input  logic             credit_in,
    input  logic             rx_in_reset,
    output logic             tx_in_reset,
    output logic [1:0]       state,
    output logic [CNT_W-1:0] credits
);

    typedef struct packed {
        tx_state_e        st;
        logic [CNT_W-1:0] cnt;
    } tx_regs_t;

    tx_regs_t r_d, r_q;
    logic     take_credit;
    logic     fire;

    always_comb begin
        r_d         = r_q;
        tx_in_reset = rst || (r_q.st == TX_RESET);
        take_credit = credit_in && !rx_in_reset && !tx_in_reset;
        up_ready    = (r_q.st == TX_ACTIVE) && (r_q.cnt != '0)
                      && !rx_in_reset && !tx_in_reset;
        fire        = up_valid && up_ready;
        link_valid  = fire;

        unique case (r_q.st)
            TX_RESET: begin
                r_d.st  = TX_WAIT;
                r_d.cnt = '0;
            end
            TX_WAIT: begin
                if (rx_in_reset) begin
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(take_credit);
                    r_d.st  = TX_ACTIVE;
                end
            end
            TX_ACTIVE: begin
                if (rx_in_reset) begin
                    r_d.cnt = '0;
                    r_d.st  = TX_WAIT;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(take_credit) - CNT_W'(fire);
                end
            end
            default: begin
                r_d.st  = TX_RESET;
                r_d.cnt = '0;
            end
        endcase

        if (rst) begin
            r_d.st  = TX_RESET;
            r_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign state   = r_q.st;
    assign credits = r_q.cnt;

endmodule

// File: rtl/credit_link_buf.sv
// In-order storage with a synchronous flush.
module credit_link_buf #(
    parameter int DEPTH = 8,
    parameter int W     = 16,
    parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty
);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [OCC_W-1:0] occ;
    } buf_regs_t;

    buf_regs_t    r_d, r_q;
    logic [W-1:0] mem [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        r_d = r_q;
        if (flush) begin
            r_d = '0;
        end else begin
            if (push) r_d.wp = bump(r_q.wp);
            if (pop)  r_d.rp = bump(r_q.rp);
            r_d.occ = r_q.occ + OCC_W'(push) - OCC_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem[r_q.wp] <= wdata;
    end

    assign rdata = mem[r_q.rp];
    assign empty = (r_q.occ == '0);

endmodule

// File: rtl/credit_link_rx.sv
// Receiving endpoint: buffer control, owed-credit counter and handshake state.
module credit_link_rx
    import credit_link_pkg::*;
#(
    parameter int CAP   = 8,
    parameter int W     = 16,
    parameter int CNT_W = $clog2(CAP + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         link_valid,
    input  logic [W-1:0] link_data,
    output logic         credit_out,
    input  logic         tx_in_reset,
    output logic         rx_in_reset,
    output logic [1:0]   state,
    output logic         dn_valid,
    output logic [W-1:0] dn_data,
    input  logic         dn_pop
);

    typedef struct packed {
        rx_state_e        st;
        logic [CNT_W-1:0] owed;
        logic             crd;
    } rx_regs_t;

    rx_regs_t r_d, r_q;
    logic     live;
    logic     push;
    logic     pop;
    logic     ret;
    logic     buf_empty;

    always_comb begin
        r_d         = r_q;
        rx_in_reset = rst || (r_q.st == RX_RESET);
        live        = (r_q.st == RX_ACTIVE) && !rx_in_reset && !tx_in_reset;
        push        = link_valid && live;
        dn_valid    = live && !buf_empty;
        pop         = dn_pop && dn_valid;
        ret         = (r_q.owed != '0);
        credit_out  = r_q.crd && !rx_in_reset && !tx_in_reset;

        unique case (r_q.st)
            RX_RESET: begin
                r_d.st   = RX_WAIT;
                r_d.owed = '0;
                r_d.crd  = 1'b0;
            end
            RX_WAIT: begin
                r_d.crd = 1'b0;
                if (tx_in_reset) begin
                    r_d.owed = '0;
                end else begin
                    r_d.owed = CNT_W'(CAP);
                    r_d.st   = RX_ACTIVE;
                end
            end
            RX_ACTIVE: begin
                if (tx_in_reset) begin
                    r_d.st   = RX_WAIT;
                    r_d.owed = '0;
                    r_d.crd  = 1'b0;
                end else begin
                    r_d.owed = r_q.owed + CNT_W'(pop) - CNT_W'(ret);
                    r_d.crd  = ret;
                end
            end
            default: begin
                r_d.st   = RX_RESET;
                r_d.owed = '0;
                r_d.crd  = 1'b0;
            end
        endcase

        if (rst) begin
            r_d.st   = RX_RESET;
            r_d.owed = '0;
            r_d.crd  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    credit_link_buf #(
        .DEPTH(CAP),
        .W    (W)
    ) store_i (
        .clk  (clk),
        .flush(!live),
        .push (push),
        .wdata(link_data),
        .pop  (pop),
        .rdata(dn_data),
        .empty(buf_empty)
    );

    assign state = r_q.st;

endmodule

// File: rtl/credit_link.sv
// Credit link: sender and receiver endpoints joined by valid, credit and status wires.
module credit_link #(
    parameter  int CAP    = 8,
    parameter  int DATA_W = 16,
    localparam int CNT_W  = $clog2(CAP + 1)
) (
    input  logic              clk,
    input  logic              snd_rst,
    input  logic              rcv_rst,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ready,
    output logic              sink_valid,
    output logic [DATA_W-1:0] sink_data,
    input  logic              sink_pop,
    output logic [CNT_W-1:0]  snd_credits,
    output logic [1:0]        snd_state,
    output logic [1:0]        rcv_state,
    output logic              snd_in_reset,
    output logic              rcv_in_reset
);

    logic link_valid;
    logic link_credit;

    credit_link_tx #(
        .CAP  (CAP),
        .CNT_W(CNT_W)
    ) tx_i (
        .clk        (clk),
        .rst        (snd_rst),
        .up_valid   (src_valid),
        .up_ready   (src_ready),
        .link_valid (link_valid),
        .credit_in  (link_credit),
        .rx_in_reset(rcv_in_reset),
        .tx_in_reset(snd_in_reset),
        .state      (snd_state),
        .credits    (snd_credits)
    );

    credit_link_rx #(
        .CAP  (CAP),
        .W    (DATA_W),
        .CNT_W(CNT_W)
    ) rx_i (
        .clk        (clk),
        .rst        (rcv_rst),
        .link_valid (link_valid),
        .link_data  (src_data),
        .credit_out (link_credit),
        .tx_in_reset(snd_in_reset),
        .rx_in_reset(rcv_in_reset),
        .state      (rcv_state),
        .dn_valid   (sink_valid),
        .dn_data    (sink_data),
        .dn_pop     (sink_pop)
    );

endmodule

// File: rtl/credit_link_chk.sv
module credit_link_chk #(
    parameter int CAP   = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             snd_rst,
    input logic             rcv_rst,
    input logic             src_ready,
    input logic             sink_valid,
    input logic [CNT_W-1:0] snd_credits,
    input logic [1:0]       snd_state,
    input logic [1:0]       rcv_state,
    input logic             snd_in_reset,
    input logic             rcv_in_reset
);

    // R1
    ready_needs_credit_chk: assert property (@(posedge clk) disable iff (snd_rst && rcv_rst)
        src_ready |-> (snd_state == 2'd2) && (snd_credits != '0));

    // R2
    status_trails_reset_chk: assert property (@(posedge clk) disable iff (snd_rst && rcv_rst)
        snd_rst |=> snd_in_reset && (snd_state == 2'd0));

    // R3
    partner_reset_clears_chk: assert property (@(posedge clk) disable iff (snd_rst && rcv_rst)
        rcv_in_reset |=> (snd_credits == '0) && (snd_state != 2'd2));

    // R4
    wait_holds_chk: assert property (@(posedge clk) disable iff (snd_rst && rcv_rst)
        (snd_state == 2'd1) && rcv_in_reset |=> (snd_state != 2'd2));

    // R4
    wait_advances_chk: assert property (@(posedge clk) disable iff (snd_rst && rcv_rst)
        (snd_state == 2'd1) && !rcv_in_reset && !snd_rst |=> (snd_state == 2'd2));

    // R5
    credit_step_chk: assert property (@(posedge clk) disable iff (snd_rst && rcv_rst)
        !snd_rst |=> (int'(snd_credits) <= int'($past(snd_credits)) + 1));

    // R6
    sender_reset_flush_chk: assert property (@(posedge clk) disable iff (snd_rst && rcv_rst)
        snd_in_reset |=> (rcv_state != 2'd2) && !sink_valid);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (snd_rst && rcv_rst)
        !snd_rst |=> (int'(snd_credits) <= CAP));

    // R9
    gated_in_reset_chk: assert property (@(posedge clk) disable iff (snd_rst && rcv_rst)
        (snd_in_reset || rcv_in_reset) |-> !src_ready && !sink_valid);

endmodule

bind credit_link credit_link_chk #(
    .CAP  (CAP),
    .CNT_W(CNT_W)
) chk_i (
    .clk         (clk),
    .snd_rst     (snd_rst),
    .rcv_rst     (rcv_rst),
    .src_ready   (src_ready),
    .sink_valid  (sink_valid),
    .snd_credits (snd_credits),
    .snd_state   (snd_state),
    .rcv_state   (rcv_state),
    .snd_in_reset(snd_in_reset),
    .rcv_in_reset(rcv_in_reset)
);

// File: tb/credit_link_tb_top.sv
module credit_link_tb_top;

    localparam int CLK_NS = 10;
    localparam int CAP    = 8;
    localparam int DW     = 16;
    localparam int CW     = $clog2(CAP + 1);

    logic          clk;
    logic          snd_rst, rcv_rst;
    logic          src_valid, src_ready;
    logic [DW-1:0] src_data;
    logic          sink_valid, sink_pop;
    logic [DW-1:0] sink_data;
    logic [CW-1:0] snd_credits;
    logic [1:0]    snd_state, rcv_state;
    logic          snd_in_reset, rcv_in_reset;

    credit_link #(.CAP(CAP), .DATA_W(DW)) dut_i (
        .clk(clk), .snd_rst(snd_rst), .rcv_rst(rcv_rst),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .sink_valid(sink_valid), .sink_data(sink_data), .sink_pop(sink_pop),
        .snd_credits(snd_credits), .snd_state(snd_state), .rcv_state(rcv_state),
        .snd_in_reset(snd_in_reset), .rcv_in_reset(rcv_in_reset)
    );

    initial clk = 1'b0;
    always #(CLK_NS / 2) clk = ~clk;

    int            n_chk = 0;
    int            n_bad = 0;
    logic [DW-1:0] q[$];
    logic [DW-1:0] tag = '0;
    int            prev_cr = 0;

    function automatic int exp_refill_cycle();
        return CAP + 4;
    endfunction

    function automatic int exp_idle_credits(int stored);
        return CAP - stored;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input logic sv, input logic sp, input logic sr, input logic rr);
        @(negedge clk);
        src_valid = sv;
        src_data  = tag;
        sink_pop  = sp;
        snd_rst   = sr;
        rcv_rst   = rr;
        #1;
        if (int'(snd_credits) > prev_cr)
            check("R5", "credit rise per cycle", int'(snd_credits) - prev_cr, 1);
        prev_cr = int'(snd_credits);
        if (sr || rr)
            check("R9", "ready or valid during reset", int'(src_ready | sink_valid), 0);
        if (sink_valid && sink_pop) begin
            if (q.size() == 0) check("R7", "pop with nothing expected", 1, 0);
            else begin
                check("R7", "beat data in order", int'(sink_data), int'(q[0]));
                void'(q.pop_front());
            end
        end
        if (src_valid && src_ready) begin
            q.push_back(tag);
            tag++;
        end
        if (sr || rr) q.delete();
    endtask

    task automatic settle(input string req);
        repeat (CAP + 8) cyc(1'b0, 1'b0, 1'b0, 1'b0);
        check(req, "idle credits vs stored", int'(snd_credits), exp_idle_credits(q.size()));
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int idx;
        int sr_left;
        int rr_left;
        void'($urandom(32'h1c3d));
        snd_rst = 1'b1; rcv_rst = 1'b1;
        src_valid = 1'b0; sink_pop = 1'b0; src_data = '0;

        // R2 / R9: reset state
        repeat (3) cyc(1'b0, 1'b0, 1'b1, 1'b1);
        check("R2", "snd_state in reset", int'(snd_state), 0);
        check("R2", "rcv_state in reset", int'(rcv_state), 0);
        check("R2", "status wires", int'({snd_in_reset, rcv_in_reset}), 3);
        check("R9", "credits in reset", int'(snd_credits), 0);

        // R2 / R4: sender released, receiver held
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        check("R2", "snd status one cycle past release", int'(snd_in_reset), 1);
        repeat (5) cyc(1'b0, 1'b0, 1'b0, 1'b1);
        check("R2", "snd status after release", int'(snd_in_reset), 0);
        check("R4", "sender waits for partner", int'(snd_state), 1);
        check("R4", "no credit while partner in reset", int'(snd_credits), 0);

        // R5: refill timing after both released (re-enter from common reset)
        cyc(1'b0, 1'b0, 1'b1, 1'b1);
        cyc(1'b0, 1'b0, 1'b1, 1'b1);
        idx = 0;
        for (int i = 1; i <= 40; i++) begin
            cyc(1'b0, 1'b0, 1'b0, 1'b0);
            if (int'(snd_credits) == CAP && idx == 0) idx = i;
        end
        check("R5", "refill cycle", idx, exp_refill_cycle());
        check("R4", "sender active", int'(snd_state), 2);
        check("R8", "no overshoot", int'(snd_credits), CAP);

        // R1 / R7: fill buffer, then drain
        repeat (CAP + 3) cyc(1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
        check("R1", "ready with no credit", int'(src_ready), 0);
        check("R1", "credits when full", int'(snd_credits), 0);
        check("R1", "beats accepted", q.size(), CAP);
        repeat (CAP + 2) cyc(1'b0, 1'b1, 1'b0, 1'b0);
        check("R7", "drained", q.size(), 0);
        settle("R7");

        // R3: receiver reset with credits held
        repeat (3) cyc(1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        check("R3", "credits after partner reset", int'(snd_credits), 0);
        check("R3", "sender back to waiting", int'(snd_state), 1);
        settle("R8");

        // R6: one-cycle sender reset with stored beats
        repeat (3) cyc(1'b1, 1'b0, 1'b0, 1'b0);
        check("R7", "stored before sender reset", q.size(), 3);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
        check("R6", "receiver waiting", int'(rcv_state), 1);
        check("R6", "no stale beat", int'(sink_valid), 0);
        settle("R8");
        check("R6", "buffer flushed", int'(sink_valid), 0);

        // R8: both sides reset in the same cycle
        repeat (2) cyc(1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b1, 1'b1);
        settle("R8");

        // R8 / R7: random traffic with independent resets
        for (int ep = 0; ep < 200; ep++) begin
            int len;
            len = 20 + int'($urandom % 40);
            sr_left = 0;
            rr_left = 0;
            for (int c = 0; c < len; c++) begin
                if (sr_left > 0) sr_left--;
                else if ($urandom % 100 < 3) sr_left = 1 + int'($urandom % 4);
                if (rr_left > 0) rr_left--;
                else if ($urandom % 100 < 3) rr_left = 1 + int'($urandom % 4);
                cyc(($urandom % 100) < 60, ($urandom % 100) < 50, sr_left > 0, rr_left > 0);
            end
            settle("R8");
        end

        finish_run();
    end

endmodule